// File: doc/BRIEF.md
# Bus Clock Prescaler Tree

This block derives every bus-rate enable of a chip from a single fast reference clock. A 32-bit configuration word chooses the system clock source and the divide ratios of one high-speed bus domain and two peripheral bus domains. The block turns those choices into single-cycle enable strobes in the reference domain. No clock is gated or generated here: downstream logic stays on the reference clock and qualifies its flops with the strobe of its domain.

The high-speed bus divider counts reference cycles. Each peripheral divider counts only high-speed bus strobes, so every peripheral strobe falls on a high-speed strobe. Each peripheral domain also has a timer strobe. When that domain is divided, the timer strobe fires twice per peripheral period; when the domain runs 1:1, it equals the peripheral strobe. A system tick runs at one eighth of the high-speed bus rate, and a core strobe follows the high-speed bus strobe.

A ratio change never cuts a period short. Each divider finishes its current period with the old ratio and picks up the new one at its next strobe. The configuration word is written through a one-cycle write port and is always visible on a read port.

Top module: `bus_prescale_tree`

## Requirements
- R1: After the synchronous active-high reset, the configuration reads back as 0 and the source select is 0. The high-speed bus, core, both peripheral and both timer strobes fire on every reference cycle, and the tick fires on every eighth cycle.
- R2: A write of a word whose bits [1:0] are not 3 is returned unchanged on the read port from the cycle after the write.
- R3: Bits [1:0] select the source: 0 internal oscillator, 1 external oscillator, 2 PLL. Writing 3 stores every other bit but keeps the previous source code, both on the source output and on the read port.
- R4: Bits [7:4] set the high-speed bus ratio. Codes 0 to 7 divide by 1. Codes 8 to 11 divide by 2, 4, 8 and 16. Codes 12 to 15 divide by 64, 128, 256 and 512. No code gives 32.
- R5: Bits [12:10] set the first peripheral ratio and bits [15:13] the second. Codes 0 to 3 divide by 1, and codes 4 to 7 divide by 2, 4, 8 and 16 of the high-speed bus rate. A peripheral strobe only fires together with a high-speed bus strobe.
- R6: When a peripheral field has its top bit set (bit 12 or bit 15), that domain's timer strobe fires twice per peripheral period: on the peripheral strobe and on the high-speed strobe halfway through the period. With the bit clear, the timer strobe equals the peripheral strobe.
- R7: The tick strobe fires on every eighth high-speed bus strobe, and the core strobe equals the high-speed bus strobe.
- R8: A new ratio takes effect only at the end of the current period of that divider. The period in progress runs out at the old length, and the next period has the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Stored configuration word |
| src_sel | output | 2 | Active system source code |
| ahb_en | output | 1 | High-speed bus enable strobe |
| core_en | output | 1 | Free-running core enable strobe |
| apb1_en | output | 1 | First peripheral bus enable strobe |
| apb2_en | output | 1 | Second peripheral bus enable strobe |
| tmr1_en | output | 1 | First peripheral timer enable strobe |
| tmr2_en | output | 1 | Second peripheral timer enable strobe |
| tick_en | output | 1 | System tick enable strobe |

## Verification
The hardest case to reach is a ratio write that lands in the middle of a long period. Only then can a shortened or doubled period appear. To reach it, the stimulus finds a high-speed strobe under the /512 ratio, waits 100 cycles, writes /2, and measures the gap to the next strobe and the gap after it. It then repeats the switch in the other direction, writing on the cycle right after a /2 strobe. The deepest nesting is a /512 bus with a /16 peripheral, where one peripheral period spans 8192 reference cycles. Every encoding is therefore checked by counting strobes over a window that is a whole multiple of all periods, after a settling time long enough for both the old and the new periods to end.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
    localparam int CFG_W          = 32;
    localparam int SRC_W          = 2;
    localparam int AHB_LSB        = 4;
    localparam int AHB_W          = 4;
    localparam int APB1_LSB       = 10;
    localparam int APB_W          = 3;
    localparam int APB_COUNT      = 2;
    localparam int AHB_SHIFT_MAX  = 9;
    localparam int APB_SHIFT_MAX  = 4;
    localparam int AHB_SH_W       = $clog2(AHB_SHIFT_MAX + 1);
    localparam int APB_SH_W       = $clog2(APB_SHIFT_MAX + 1);

    typedef enum logic [SRC_W-1:0] {
        SRC_INT  = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_PLL  = 2'd2,
        SRC_RSVD = 2'd3
    } src_e;

    // Ratio code to power-of-two exponent; the /32 step is skipped.
    function automatic logic [AHB_SH_W-1:0] ahb_shift(input logic [AHB_W-1:0] code);
        logic [AHB_SH_W-1:0] low;
        low = AHB_SH_W'(code[1:0]);
        if (!code[3])      return '0;
        else if (code[2])  return low + AHB_SH_W'(6);
        else               return low + AHB_SH_W'(1);
    endfunction

    function automatic logic [APB_SH_W-1:0] apb_shift(input logic [APB_W-1:0] code);
        if (code[2]) return APB_SH_W'(code[1:0]) + APB_SH_W'(1);
        else         return '0;
    endfunction
endpackage

// File: rtl/bpt_div_stage.sv
module bpt_div_stage #(
    parameter int SHIFT_MAX = 9,
    parameter int SH_W      = 4,
    parameter bit HAS_DBL   = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    input  logic [SH_W-1:0] shift_in,
    output logic            tick,
    output logic            dbl_tick
);
    localparam int CNT_W = (SHIFT_MAX < 1) ? 1 : SHIFT_MAX;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SH_W-1:0]  shift;
    } stage_t;

    stage_t           st_d, st_q;
    logic [CNT_W-1:0] one_c;
    logic [CNT_W-1:0] load_c;

    always_comb begin
        one_c  = {{(CNT_W-1){1'b0}}, 1'b1};
        // (1 << shift) - 1 wraps correctly when shift equals CNT_W
        load_c = (one_c << shift_in) - one_c;
        tick   = adv && (st_q.cnt == '0);
        st_d   = st_q;
        if (tick) begin
            st_d.shift = shift_in;
            st_d.cnt   = load_c;
        end else if (adv) begin
            st_d.cnt   = st_q.cnt - one_c;
        end
    end

    generate
        if (HAS_DBL) begin : g_dbl
            logic [CNT_W-1:0] half_c;
            always_comb begin
                if (st_q.shift == '0) begin
                    half_c   = '0;
                    dbl_tick = tick;
                end else begin
                    half_c   = one_c << (st_q.shift - {{(SH_W-1){1'b0}}, 1'b1});
                    dbl_tick = adv && ((st_q.cnt == '0) || (st_q.cnt == half_c));
                end
            end
        end else begin : g_plain
            assign dbl_tick = tick;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/bus_prescale_tree.sv
module bus_prescale_tree
    import bpt_pkg::*;
#(
    parameter int TICK_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic [SRC_W-1:0] src_sel,
    output logic             ahb_en,
    output logic             core_en,
    output logic             apb1_en,
    output logic             apb2_en,
    output logic             tmr1_en,
    output logic             tmr2_en,
    output logic             tick_en
);
    typedef struct packed {
        logic [CFG_W-1:0]     cfg;
        logic [TICK_LOG2-1:0] tcnt;
    } top_t;

    top_t                 st_d, st_q;
    logic [APB_COUNT-1:0] apb_w;
    logic [APB_COUNT-1:0] tmr_w;
    logic                 dbl_unused;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.cfg = cfg_wdata;
            if (src_e'(cfg_wdata[SRC_W-1:0]) == SRC_RSVD)
                st_d.cfg[SRC_W-1:0] = st_q.cfg[SRC_W-1:0];
        end
        if (ahb_en)
            st_d.tcnt = st_q.tcnt + {{(TICK_LOG2-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    bpt_div_stage #(
        .SHIFT_MAX (AHB_SHIFT_MAX),
        .SH_W      (AHB_SH_W),
        .HAS_DBL   (1'b0)
    ) u_ahb (
        .clk      (clk),
        .rst      (rst),
        .adv      (1'b1),
        .shift_in (ahb_shift(st_q.cfg[AHB_LSB +: AHB_W])),
        .tick     (ahb_en),
        .dbl_tick (dbl_unused)
    );

    generate
        for (genvar g = 0; g < APB_COUNT; g++) begin : g_apb
            localparam int LSB = APB1_LSB + g * APB_W;
            bpt_div_stage #(
                .SHIFT_MAX (APB_SHIFT_MAX),
                .SH_W      (APB_SH_W),
                .HAS_DBL   (1'b1)
            ) u_stage (
                .clk      (clk),
                .rst      (rst),
                .adv      (ahb_en),
                .shift_in (apb_shift(st_q.cfg[LSB +: APB_W])),
                .tick     (apb_w[g]),
                .dbl_tick (tmr_w[g])
            );
        end
    endgenerate

    assign cfg_rdata = st_q.cfg;
    assign src_sel   = st_q.cfg[SRC_W-1:0];
    assign core_en   = ahb_en;
    assign tick_en   = ahb_en && (&st_q.tcnt);
    assign apb1_en   = apb_w[0];
    assign apb2_en   = apb_w[1];
    assign tmr1_en   = tmr_w[0];
    assign tmr2_en   = tmr_w[1];
endmodule

// File: rtl/bpt_chk.sv
module bpt_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic [1:0]  src_sel,
    input logic        ahb_en,
    input logic        apb1_en,
    input logic        apb2_en,
    input logic        tmr1_en,
    input logic        tmr2_en,
    input logic        tick_en
);
    a_r2_readback: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wdata[1:0] != 2'b11) |=> (cfg_rdata == $past(cfg_wdata)));

    a_r3_src_legal: assert property (@(posedge clk) disable iff (rst)
        src_sel != 2'b11);

    a_r3_rsvd_hold: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wdata[1:0] == 2'b11) |=> $stable(src_sel));

    a_r5_apb1_on_ahb: assert property (@(posedge clk) disable iff (rst)
        apb1_en |-> ahb_en);

    a_r5_apb2_on_ahb: assert property (@(posedge clk) disable iff (rst)
        apb2_en |-> ahb_en);

    a_r6_tmr1_has_apb: assert property (@(posedge clk) disable iff (rst)
        apb1_en |-> tmr1_en);

    a_r6_tmr2_has_apb: assert property (@(posedge clk) disable iff (rst)
        apb2_en |-> tmr2_en);

    a_r6_tmr_on_ahb: assert property (@(posedge clk) disable iff (rst)
        (tmr1_en || tmr2_en) |-> ahb_en);

    a_r7_tick_on_ahb: assert property (@(posedge clk) disable iff (rst)
        tick_en |-> ahb_en);

    a_r7_tick_isolated: assert property (@(posedge clk) disable iff (rst)
        tick_en |=> !tick_en);
endmodule

bind bus_prescale_tree bpt_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .src_sel   (src_sel),
    .ahb_en    (ahb_en),
    .apb1_en   (apb1_en),
    .apb2_en   (apb2_en),
    .tmr1_en   (tmr1_en),
    .tmr2_en   (tmr2_en),
    .tick_en   (tick_en)
);

// File: tb/sim_bus_prescale_tree.sv
module sim_bus_prescale_tree;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [1:0]  src_sel;
    logic        ahb_en, core_en, apb1_en, apb2_en, tmr1_en, tmr2_en, tick_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int prev_span = 1;

    always #4 clk = ~clk;

    bus_prescale_tree u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .src_sel(src_sel), .ahb_en(ahb_en),
        .core_en(core_en), .apb1_en(apb1_en), .apb2_en(apb2_en),
        .tmr1_en(tmr1_en), .tmr2_en(tmr2_en), .tick_en(tick_en)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ahb_div(input logic [3:0] c);
        case (c)
            4'h8: return 2;   4'h9: return 4;   4'hA: return 8;   4'hB: return 16;
            4'hC: return 64;  4'hD: return 128; 4'hE: return 256; 4'hF: return 512;
            default: return 1;
        endcase
    endfunction

    function automatic int apb_div(input logic [2:0] c);
        case (c)
            3'd4: return 2; 3'd5: return 4; 3'd6: return 8; 3'd7: return 16;
            default: return 1;
        endcase
    endfunction

    function automatic logic [31:0] mk(input logic [1:0] s, input logic [3:0] a,
                                       input logic [2:0] p1, input logic [2:0] p2);
        return {16'h0, p2, p1, 2'b00, a, 2'b00, s};
    endfunction

    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Set a ratio triple, settle, then count strobes over a whole-period window.
    task automatic run_ratio(input string req, input logic [3:0] a, input logic [2:0] p1, input logic [2:0] p2);
        int ad, d1, d2, span, w, n_ahb, n_core, n_a1, n_a2, n_t1, n_t2, n_tk, m;
        ad = ahb_div(a); d1 = apb_div(p1); d2 = apb_div(p2);
        m = (d1 > d2) ? d1 : d2;
        span = ad * m;
        write_cfg(mk(2'd0, a, p1, p2));
        repeat (2 * (prev_span + span) + 16) @(negedge clk);
        prev_span = span;
        w = ad * ((m > 8) ? m : 8) * 2;
        n_ahb = 0; n_core = 0; n_a1 = 0; n_a2 = 0; n_t1 = 0; n_t2 = 0; n_tk = 0;
        repeat (w) begin
            @(negedge clk);
            n_ahb += int'(ahb_en);  n_core += int'(core_en);
            n_a1  += int'(apb1_en); n_a2   += int'(apb2_en);
            n_t1  += int'(tmr1_en); n_t2   += int'(tmr2_en);
            n_tk  += int'(tick_en);
        end
        check({req, " R4"}, "ahb count", n_ahb, w / ad);
        check({req, " R7"}, "core count", n_core, w / ad);
        check({req, " R5"}, "apb1 count", n_a1, w / (ad * d1));
        check({req, " R5"}, "apb2 count", n_a2, w / (ad * d2));
        check({req, " R6"}, "tmr1 count", n_t1, (d1 > 1) ? 2 * w / (ad * d1) : w / ad);
        check({req, " R6"}, "tmr2 count", n_t2, (d2 > 1) ? 2 * w / (ad * d2) : w / ad);
        check({req, " R7"}, "tick count", n_tk, w / (8 * ad));
    endtask

    task automatic t_reset();
        int n_ahb, n_a1, n_a2, n_t1, n_t2, n_tk;
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        check("R1", "rdata after reset", cfg_rdata, 0);
        check("R1", "src after reset", src_sel, 0);
        n_ahb = 0; n_a1 = 0; n_a2 = 0; n_t1 = 0; n_t2 = 0; n_tk = 0;
        repeat (64) begin
            @(negedge clk);
            n_ahb += int'(ahb_en);  n_a1 += int'(apb1_en); n_a2 += int'(apb2_en);
            n_t1  += int'(tmr1_en); n_t2 += int'(tmr2_en); n_tk += int'(tick_en);
        end
        check("R1", "ahb every cycle", n_ahb, 64);
        check("R1", "apb1 every cycle", n_a1, 64);
        check("R1", "apb2 every cycle", n_a2, 64);
        check("R1", "tmr1 every cycle", n_t1, 64);
        check("R1", "tmr2 every cycle", n_t2, 64);
        check("R1", "tick every 8th", n_tk, 8);
    endtask

    task automatic t_readback();
        write_cfg(32'hFFFF_0302);
        check("R2", "readback plain", cfg_rdata, 32'hFFFF_0302);
        write_cfg(32'h1234_0003);
        check("R3", "readback rsvd src", cfg_rdata, 32'h1234_0002);
        write_cfg(32'h0);
        check("R2", "readback zero", cfg_rdata, 0);
    endtask

    task automatic t_source();
        write_cfg(32'h1); check("R3", "src ext", src_sel, 1);
        write_cfg(32'h2); check("R3", "src pll", src_sel, 2);
        write_cfg(32'h3); check("R3", "src rsvd keeps pll", src_sel, 2);
        write_cfg(32'h0); check("R3", "src int", src_sel, 0);
        write_cfg(32'h3); check("R3", "src rsvd keeps int", src_sel, 0);
    endtask

    task automatic t_ahb_sweep();
        logic [3:0] codes [9] = '{4'h3, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF};
        foreach (codes[i]) run_ratio("R4 sweep", codes[i], 3'd0, 3'd0);
    endtask

    task automatic t_apb_sweep();
        run_ratio("R5 pair", 4'h8, 3'd2, 3'd7);
        run_ratio("R5 pair", 4'h8, 3'd4, 3'd5);
        run_ratio("R5 pair", 4'h8, 3'd5, 3'd4);
        run_ratio("R5 pair", 4'h9, 3'd6, 3'd3);
        run_ratio("R6 pair", 4'h0, 3'd7, 3'd6);
    endtask

    task automatic t_deep();
        run_ratio("R6 deep", 4'hF, 3'd7, 3'd4);
    endtask

    // Gap in reference cycles to the next high-speed strobe, with an optional write on the way.
    task automatic gap(input int wr_at, input logic [31:0] w, output int n);
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (n == wr_at) begin cfg_we = 1'b1; cfg_wdata = w; end
            else cfg_we = 1'b0;
            if (ahb_en) break;
        end
        cfg_we = 1'b0;
    endtask

    task automatic t_boundary();
        int n;
        write_cfg(mk(2'd0, 4'hF, 3'd0, 3'd0));
        repeat (2 * (prev_span + 512) + 16) @(negedge clk);
        prev_span = 512;
        gap(0, 32'h0, n);
        gap(100, mk(2'd0, 4'h8, 3'd0, 3'd0), n);
        check("R8", "slow period not cut", n, 512);
        gap(0, 32'h0, n);
        check("R8", "new fast period", n, 2);
        gap(1, mk(2'd0, 4'hF, 3'd0, 3'd0), n);
        check("R8", "fast period not stretched", n, 2);
        gap(0, 32'h0, n);
        check("R8", "new slow period", n, 512);
    endtask

    initial begin
        t_reset();
        t_readback();
        t_source();
        t_ahb_sweep();
        t_apb_sweep();
        t_deep();
        t_boundary();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule